// File: doc/BRIEF.md
# Vector Subnormal Flush Unit

This block conditions a 128-bit vector made of four IEEE-754 single-precision lanes before or after a vector floating-point operation. A run-time mode bit, held in a small software-visible control word, decides what happens to subnormal lanes.

When the mode bit is set, every subnormal lane is replaced by a zero of the same sign. When the bit is clear, the vector goes through untouched. In both modes the block reports, for every lane, whether that lane is a zero and whether it is subnormal.

The path from vector input to vector output is purely combinational, so one copy can sit on each operand port of an arithmetic pipe and another on its result. The mode bit comes out of reset set or clear according to the byte-order mode input.

Top module: `vec_denorm_flush`

## Requirements
- R1: A lane whose exponent field (bits 30:23 of the lane) is all zeros and whose fraction field (bits 22:0) is nonzero raises that lane's bit in `subnFlags`, in both modes.
- R2: A lane whose exponent and fraction fields are both all zeros raises that lane's bit in `zeroFlags`, whatever its sign bit (bit 31). Otherwise the bit is clear.
- R3: With the flush bit set, a subnormal lane appears at the output as its sign bit with all other 31 bits cleared.
- R4: With the flush bit set, normal, zero, infinity and NaN lanes appear at the output unchanged.
- R5: With the flush bit clear, all four lanes appear at the output unchanged, subnormal ones included.
- R6: The control word keeps only bit 16 (flush bit) and bit 0. Every other bit reads back as 0, whatever was written.
- R7: During reset, bit 16 of the control word takes the value of `bigEndianMode` and bit 0 becomes 0.
- R8: A control-word write shows in `ctrlRdData` and in the flush behaviour only after the next rising clock edge. The vector output follows the vector input in the same cycle.
- R9: Lane i occupies bits [32*i+31 : 32*i] of the vectors, and its flags sit at bit i of `zeroFlags` and `subnFlags`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the control word |
| rstN | input | 1 | Synchronous active-low reset |
| bigEndianMode | input | 1 | Byte-order mode; sets the flush bit's reset value |
| ctrlWrEn | input | 1 | Control-word write strobe |
| ctrlWrData | input | 32 | Control-word write data |
| ctrlRdData | output | 32 | Control-word read data |
| vecIn | input | 128 | Four single-precision lanes in |
| vecOut | output | 128 | Conditioned lanes out |
| zeroFlags | output | 4 | Per-lane zero indication |
| subnFlags | output | 4 | Per-lane subnormal indication |

## Verification
The bench builds the block with its default parameters: four 32-bit lanes with 8-bit exponents, and the flush bit at position 16. With these values every lane can carry a different class in one vector (positive and negative subnormal, signed zeros, smallest normal, infinity, quiet NaN), so lane independence and lane ordering are checked together. Resetting once with each byte-order setting covers both reset values of the flush bit.

// File: rtl/vdf_pkg.sv
package vdf_pkg;
  // Strobes from the control word to the datapath
  typedef struct packed {
    logic flushEn;
    logic auxBit;
  } ctrlStrobes_t;
endpackage

// File: rtl/vdf_ctrl.sv
module vdf_ctrl
  import vdf_pkg::*;
#(
  parameter int CTRL_W    = 32,
  parameter int FLUSH_POS = 16,
  parameter int AUX_POS   = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bigEndianMode,
  input  logic              ctrlWrEn,
  input  logic [CTRL_W-1:0] ctrlWrData,
  output logic [CTRL_W-1:0] ctrlRdData,
  output ctrlStrobes_t      strobes
);
  localparam logic [CTRL_W-1:0] WR_MASK =
    (CTRL_W'(1) << FLUSH_POS) | (CTRL_W'(1) << AUX_POS);

  logic flushQ;
  logic auxQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flushQ <= bigEndianMode;
      auxQ   <= 1'b0;
    end else if (ctrlWrEn) begin
      flushQ <= ctrlWrData[FLUSH_POS];
      auxQ   <= ctrlWrData[AUX_POS];
    end
  end

  always_comb begin
    ctrlRdData            = '0;
    ctrlRdData[FLUSH_POS] = flushQ;
    ctrlRdData[AUX_POS]   = auxQ;
    strobes.flushEn       = flushQ;
    strobes.auxBit        = auxQ;
  end

  // A write lands, masked, one edge later
  assert_write_lands_R8: assert property (@(posedge clk) disable iff (!rstN)
    ctrlWrEn |=> ctrlRdData == ($past(ctrlWrData) & WR_MASK));

  // Without a write, the word holds
  assert_word_holds_R6: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlWrEn |=> $stable(ctrlRdData));

  // The datapath strobe follows the stored flush bit
  assert_strobe_match_R8: assert property (@(posedge clk) disable iff (!rstN)
    strobes.flushEn == ctrlRdData[FLUSH_POS]);
endmodule

// File: rtl/vdf_lane.sv
module vdf_lane #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic                      flushEn,
  input  logic [EXP_W+FRAC_W:0]     laneIn,
  output logic [EXP_W+FRAC_W:0]     laneOut,
  output logic                      isZero,
  output logic                      isSubn
);
  localparam int LANE_W = 1 + EXP_W + FRAC_W;

  logic [EXP_W-1:0]  expField;
  logic [FRAC_W-1:0] fracField;
  logic              expAllZero;
  logic              fracAllZero;

  always_comb begin
    expField    = laneIn[LANE_W-2 -: EXP_W];
    fracField   = laneIn[FRAC_W-1:0];
    expAllZero  = ~|expField;
    fracAllZero = ~|fracField;
    isZero      = expAllZero & fracAllZero;
    isSubn      = expAllZero & ~fracAllZero;
    if (flushEn && isSubn) laneOut = {laneIn[LANE_W-1], {(LANE_W-1){1'b0}}};
    else                   laneOut = laneIn;
  end

  always_comb begin
    if (!$isunknown({flushEn, laneIn})) begin
      // sign never changes
      assert_sign_kept_R3: assert (laneOut[LANE_W-1] == laneIn[LANE_W-1]);
      // infinities and NaNs untouched
      assert_special_untouched_R4: assert (!(&expField) || laneOut == laneIn);
      // pass-through when flush is off
      assert_passthru_R5: assert (flushEn || laneOut == laneIn);
    end
  end
endmodule

// File: rtl/vdf_datapath.sv
module vdf_datapath
  import vdf_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  ctrlStrobes_t                        strobes,
  input  logic [LANES*(1+EXP_W+FRAC_W)-1:0]   vecIn,
  output logic [LANES*(1+EXP_W+FRAC_W)-1:0]   vecOut,
  output logic [LANES-1:0]                    zeroFlags,
  output logic [LANES-1:0]                    subnFlags
);
  localparam int LANE_W = 1 + EXP_W + FRAC_W;

  for (genvar i = 0; i < LANES; i++) begin : gLane
    vdf_lane #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) uLane (
      .flushEn (strobes.flushEn),
      .laneIn  (vecIn[i*LANE_W +: LANE_W]),
      .laneOut (vecOut[i*LANE_W +: LANE_W]),
      .isZero  (zeroFlags[i]),
      .isSubn  (subnFlags[i])
    );
  end

  always_comb begin
    if (!$isunknown({zeroFlags, subnFlags})) begin
      // a lane is never both zero and subnormal
      assert_flags_disjoint_R1: assert ((zeroFlags & subnFlags) == '0);
    end
  end
endmodule

// File: rtl/vec_denorm_flush.sv
module vec_denorm_flush
  import vdf_pkg::*;
#(
  parameter int LANES     = 4,
  parameter int EXP_W     = 8,
  parameter int FRAC_W    = 23,
  parameter int CTRL_W    = 32,
  parameter int FLUSH_POS = 16,
  parameter int AUX_POS   = 0,
  localparam int VEC_W    = LANES * (1 + EXP_W + FRAC_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bigEndianMode,
  input  logic              ctrlWrEn,
  input  logic [CTRL_W-1:0] ctrlWrData,
  output logic [CTRL_W-1:0] ctrlRdData,
  input  logic [VEC_W-1:0]  vecIn,
  output logic [VEC_W-1:0]  vecOut,
  output logic [LANES-1:0]  zeroFlags,
  output logic [LANES-1:0]  subnFlags
);
  ctrlStrobes_t strobes;

  vdf_ctrl #(.CTRL_W(CTRL_W), .FLUSH_POS(FLUSH_POS), .AUX_POS(AUX_POS)) uCtrl (
    .clk           (clk),
    .rstN          (rstN),
    .bigEndianMode (bigEndianMode),
    .ctrlWrEn      (ctrlWrEn),
    .ctrlWrData    (ctrlWrData),
    .ctrlRdData    (ctrlRdData),
    .strobes       (strobes)
  );

  vdf_datapath #(.LANES(LANES), .EXP_W(EXP_W), .FRAC_W(FRAC_W)) uPath (
    .strobes   (strobes),
    .vecIn     (vecIn),
    .vecOut    (vecOut),
    .zeroFlags (zeroFlags),
    .subnFlags (subnFlags)
  );
endmodule

// File: tb/sim_vec_denorm_flush.sv
module sim_vec_denorm_flush;
  logic         clk = 1'b0;
  logic         rstN;
  logic         bigEndianMode;
  logic         ctrlWrEn;
  logic [31:0]  ctrlWrData;
  logic [31:0]  ctrlRdData;
  logic [127:0] vecIn;
  logic [127:0] vecOut;
  logic [3:0]   zeroFlags;
  logic [3:0]   subnFlags;

  int errors = 0;
  int checks = 0;
  bit flushModel = 1'b0;

  typedef struct {
    logic [127:0] vec;
    logic [3:0]   zf;
    logic [3:0]   sf;
    string        tag;
  } expItem_t;
  expItem_t sb[$];

  always #2 clk = ~clk;  // 250 MHz

  vec_denorm_flush u0 (
    .clk(clk), .rstN(rstN), .bigEndianMode(bigEndianMode),
    .ctrlWrEn(ctrlWrEn), .ctrlWrData(ctrlWrData), .ctrlRdData(ctrlRdData),
    .vecIn(vecIn), .vecOut(vecOut), .zeroFlags(zeroFlags), .subnFlags(subnFlags)
  );

  function automatic expItem_t model(input logic [127:0] v, input bit fl, input string tag);
    expItem_t e;
    e.tag = tag;
    for (int i = 0; i < 4; i++) begin
      logic [31:0] w;
      w = v[32*i +: 32];
      e.zf[i] = (w[30:23] == 8'h00) && (w[22:0] == 23'h0);
      e.sf[i] = (w[30:23] == 8'h00) && (w[22:0] != 23'h0);
      e.vec[32*i +: 32] = (fl && e.sf[i]) ? {w[31], 31'h0} : w;
    end
    return e;
  endfunction

  task automatic check32(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  // Driver: applies a vector and pushes its expected result
  task automatic drive(input logic [127:0] v, input string tag);
    @(posedge clk); #1;
    vecIn = v;
    sb.push_back(model(v, flushModel, tag));
  endtask

  task automatic drain();
    while (sb.size() > 0) @(negedge clk);
  endtask

  // Monitor: compares in the middle of the cycle
  initial begin
    forever begin
      @(negedge clk);
      if (sb.size() > 0) begin
        expItem_t e;
        e = sb.pop_front();
        checks++;
        if (vecOut !== e.vec || zeroFlags !== e.zf || subnFlags !== e.sf) begin
          errors++;
          $display("FAIL %s: actual=%032h z=%b s=%b expected=%032h z=%b s=%b",
                   e.tag, vecOut, zeroFlags, subnFlags, e.vec, e.zf, e.sf);
        end
      end
    end
  end

  task automatic ctrlWrite(input logic [31:0] d);
    drain();
    @(posedge clk); #1;
    ctrlWrEn = 1'b1; ctrlWrData = d;
    @(negedge clk);
    // R8: not visible before the edge
    check32("R8 pre-edge read", ctrlRdData, {15'h0, flushModel, 15'h0, ctrlRdData[0]});
    @(posedge clk); #1;
    ctrlWrEn = 1'b0;
    flushModel = d[16];
    @(negedge clk);
    check32("R6 masked readback", ctrlRdData, d & 32'h0001_0001);
  endtask

  task automatic doReset(input bit be);
    drain();
    @(posedge clk); #1;
    rstN = 1'b0; bigEndianMode = be; ctrlWrEn = 1'b0;
    repeat (2) @(posedge clk);
    #1 rstN = 1'b1;
    flushModel = be;
    @(negedge clk);
    check32("R7 reset value", ctrlRdData, {15'h0, be, 16'h0});
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    rstN = 1'b0; bigEndianMode = 1'b1; ctrlWrEn = 1'b0;
    ctrlWrData = '0; vecIn = '0;
    doReset(1'b1);
    // R1 R3 R4: lanes {NaN, normal 1.0, -subn, +subn}
    drive({32'h7FC0_0001, 32'h3F80_0000, 32'h807F_FFFF, 32'h0000_0001}, "R3 R4 flush mix");
    // R2 R4: {min normal, +inf, -0, +0}
    drive({32'h0080_0000, 32'h7F80_0000, 32'h8000_0000, 32'h0000_0000}, "R2 R4 zeros and inf");
    // R9: single subnormal in lane 2
    drive({32'h4000_0000, 32'h8000_1234, 32'hBF80_0000, 32'h0000_0000}, "R9 lane order");
    // R1: all lanes subnormal, alternating signs
    drive({32'h8040_0000, 32'h0000_0002, 32'h8000_0001, 32'h007F_FFFF}, "R1 all subnormal");
    drain();
    // R6: write all ones, then clear flush
    ctrlWrite(32'hFFFF_FFFF);
    ctrlWrite(32'h0000_0000);
    drive({32'h8040_0000, 32'h0000_0002, 32'h8000_0001, 32'h007F_FFFF}, "R5 pass subnormal");
    drive({32'h7FC0_0001, 32'h3F80_0000, 32'h807F_FFFF, 32'h0000_0001}, "R5 pass mix");
    // R8: re-enable flush, then vector follows in the same cycle
    ctrlWrite(32'h0001_0000);
    drive({32'h0000_0000, 32'h0000_0000, 32'h0000_0000, 32'h8000_0005}, "R8 flush after write");
    // R7: little-endian reset clears flush
    doReset(1'b0);
    drive({32'h0000_0003, 32'h8000_0000, 32'hFF80_0000, 32'h8012_3456}, "R7 R5 LE reset pass");
    drain();
    summary();
    $finish;
  end
endmodule